// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Data Cache

This block is a direct-mapped, write-back data cache for a 32-bit processor pipeline. A load or store presents its virtual address in the first cycle. The line index comes from the virtual address, so the data, tag and status arrays are read in that cycle while the translation unit works out the physical address. The physical address and an uncached flag reach the cache one cycle later. The stored tag is then compared against the physical address, not the virtual one. A hit returns data, or merges store bytes, in that second cycle.

On a miss the cache asserts `stall`. If the victim line is dirty, it first writes the victim back to memory as four 32-bit beats. It then refills the 128-bit line in four ascending 32-bit beats. `stall` drops in the cycle the requested word arrives, and the refill finishes in the background. An access flagged as uncached skips the arrays and makes a single word access to memory. There are 512 lines of 128 bits. The line index is virtual address bits 12:4 and the word select is bits 3:2. The tag is physical bits 31:13.

With 4 KB pages, index bit 12 lies above the untranslated page offset. Software must therefore map each page so that virtual bit 12 equals physical bit 12. If it does not, one physical line can sit in two slots, and a written-back victim is addressed with virtual bit 12.

The controller has five states:
- IDLE accepts a request and starts the array read.
- LOOKUP compares the tag and either answers or picks the miss path.
- EVICT writes back the dirty victim.
- REFILL fetches the line.
- BYPASS makes the uncached access.

The transitions are:
- IDLE→LOOKUP when a request is valid.
- LOOKUP→IDLE on a cached hit.
- LOOKUP→BYPASS when the access is uncached.
- LOOKUP→EVICT on a miss with a valid dirty victim.
- LOOKUP→REFILL on a miss with a clean or invalid victim.
- EVICT→REFILL after the fourth write beat is acknowledged.
- REFILL→IDLE after the fourth read beat is acknowledged.
- BYPASS→IDLE on acknowledge.

Top module: `vipt_dcache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `stall`, `resp_valid` and `mem_req` are 0. The first access to any address misses.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. The physical address is sampled in the next cycle (LOOKUP). A cached hit gives `resp_valid`=1 in that cycle, with the addressed 32-bit word in `resp_rdata` (word w of a line is bits 32w+31:32w), and causes no memory transfer.
- R3: The hit decision compares the stored tag with physical address bits 31:13. A different virtual tag with the same index and the same physical address hits, and the same index with a different physical tag misses.
- R4: A refill reads the line base address +0, +4, +8 and +12 in that order, with `mem_we`=0. Each beat holds `mem_req` and `mem_addr` until `mem_ack`. The new tag is installed afterwards.
- R5: On a miss, `stall` is 1 from the LOOKUP cycle until the cycle the requested word is acknowledged. In that cycle `resp_valid`=1 and `resp_rdata` = `mem_rdata`. `req_ready` returns to 1 in the cycle after the fourth read beat.
- R6: A store hit writes the bytes whose `req_be` bit is 1 (bit i covers data bits 8i+7:8i) and marks the line dirty, with no memory transfer. A later load returns the merged word.
- R7: A store miss allocates: it refills the line, merges the store bytes into the requested word, and leaves the line dirty.
- R8: A miss whose victim is valid and dirty first writes the four victim words (`mem_we`=1, `mem_be`=4'hF) to {stored tag, index, word, 2'b00} in ascending order, then refills.
- R9: A miss whose victim is clean or invalid performs no write-back.
- R10: An uncached access makes one memory transfer at the physical word address, using the request's write flag, byte enables and data. It changes no array content, so a later cached hit to that line still returns the old cached data.
- R11: `req_valid` is ignored while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual address, request cycle |
| req_be | input | 4 | Store byte enables |
| req_wdata | input | 32 | Store data |
| req_paddr | input | 32 | Translated address, cycle after request |
| pa_uncached | input | 1 | Uncached flag, cycle after request |
| req_ready | output | 1 | Cache idle, request may be accepted |
| stall | output | 1 | Requested word still outstanding |
| resp_valid | output | 1 | Access completes this cycle |
| resp_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 32 | Memory word address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory beat accepted this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
Count cycles from the accepting edge, with LOOKUP as cycle 1.
- A hit answers in cycle 1.
- The bench memory acknowledges every other cycle. A clean miss therefore answers in cycle 2+2w, where w is the word select, and becomes ready again in cycle 9.
- A dirty miss has four write beats in cycles 2 to 8, so it answers in cycle 10+2w.
- An uncached access answers in cycle 2.

Each task counts cycles from the accept edge and samples the outputs at mid low phase. It compares the cycle of the response and the cycle `req_ready` returns with these numbers, and compares the logged memory beats in order.

// File: rtl/vipt_dcache_pkg.sv
package vipt_dcache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_REFILL,
        ST_BYPASS
    } dc_state_e;

endpackage

// File: rtl/vipt_dcache_store.sv
module vipt_dcache_store #(
    parameter int LINES     = 512,
    parameter int LINE_BITS = 128,
    parameter int TAG_W     = 19,
    localparam int IDX_W    = $clog2(LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [LINE_BITS-1:0] rd_line,
    output logic [TAG_W-1:0]     rd_tag,
    output logic                 rd_valid,
    output logic                 rd_dirty,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [LINE_BITS-1:0] wr_line,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic                 wr_dirty
);

    logic [LINE_BITS-1:0] data_q [LINES];
    logic [TAG_W-1:0]     tag_q  [LINES];
    logic [LINES-1:0]     valid_q;
    logic [LINES-1:0]     dirty_q;

    // Payload arrays: no reset, validity lives in valid_q
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_line;
            tag_q[wr_idx]  <= wr_tag;
        end
    end

    // Status bits: cleared in one step by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    // Registered read started from the virtual index
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_line <= data_q[rd_idx];
            rd_tag  <= tag_q[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_dirty <= 1'b0;
        end else if (rd_en) begin
            rd_valid <= valid_q[rd_idx];
            rd_dirty <= dirty_q[rd_idx];
        end
    end

endmodule

// File: rtl/vipt_dcache_ctrl.sv
module vipt_dcache_ctrl
    import vipt_dcache_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINES     = 512,
    parameter int LINE_BITS = 128,
    parameter int WORD_BITS = 32,
    localparam int BEATS    = LINE_BITS / WORD_BITS,
    localparam int BE_W     = WORD_BITS / 8,
    localparam int IDX_W    = $clog2(LINES),
    localparam int WSEL_W   = $clog2(BEATS),
    localparam int BOFF_W   = $clog2(BE_W),
    localparam int OFF_W    = WSEL_W + BOFF_W,
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W,
    localparam int PA_W     = ADDR_W - BOFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_vaddr,
    input  logic [BE_W-1:0]      req_be,
    input  logic [WORD_BITS-1:0] req_wdata,
    input  logic [ADDR_W-1:0]    req_paddr,
    input  logic                 pa_uncached,
    output logic                 req_ready,
    output logic                 stall,
    output logic                 resp_valid,
    output logic [WORD_BITS-1:0] resp_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BE_W-1:0]      mem_be,
    output logic [WORD_BITS-1:0] mem_wdata,
    input  logic                 mem_ack,
    input  logic [WORD_BITS-1:0] mem_rdata,
    output logic                 arr_rd_en,
    output logic [IDX_W-1:0]     arr_rd_idx,
    input  logic [LINE_BITS-1:0] arr_rd_line,
    input  logic [TAG_W-1:0]     arr_rd_tag,
    input  logic                 arr_rd_valid,
    input  logic                 arr_rd_dirty,
    output logic                 arr_wr_en,
    output logic [IDX_W-1:0]     arr_wr_idx,
    output logic [LINE_BITS-1:0] arr_wr_line,
    output logic [TAG_W-1:0]     arr_wr_tag,
    output logic                 arr_wr_dirty
);

    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(BEATS - 1);

    function automatic logic [WORD_BITS-1:0] merge_bytes(
        input logic [WORD_BITS-1:0] old_w,
        input logic [WORD_BITS-1:0] new_w,
        input logic [BE_W-1:0]      be
    );
        logic [WORD_BITS-1:0] res;
        for (int b = 0; b < BE_W; b++) begin
            res[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
        end
        return res;
    endfunction

    function automatic logic [LINE_BITS-1:0] put_word(
        input logic [LINE_BITS-1:0] line,
        input logic [WSEL_W-1:0]    sel,
        input logic [WORD_BITS-1:0] w
    );
        logic [LINE_BITS-1:0] res;
        res = line;
        res[WORD_BITS*sel +: WORD_BITS] = w;
        return res;
    endfunction

    dc_state_e             state_q, state_d;
    logic [IDX_W-1:0]      idx_q;
    logic [WSEL_W-1:0]     wsel_q;
    logic                  we_q;
    logic [BE_W-1:0]       be_q;
    logic [WORD_BITS-1:0]  wdata_q;
    logic [PA_W-1:0]       pa_q;
    logic [WSEL_W-1:0]     beat_q;
    logic [LINE_BITS-1:0]  fill_q;
    logic                  given_q;

    logic [TAG_W-1:0]      pa_tag;
    logic                  hit;
    logic [WORD_BITS-1:0]  hit_word;
    logic [WORD_BITS-1:0]  beat_word;
    logic                  beat_done;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{req_vaddr[ADDR_W-1:OFF_W+IDX_W],
                                req_vaddr[BOFF_W-1:0],
                                req_paddr[BOFF_W-1:0]};

    assign pa_tag    = req_paddr[ADDR_W-1 -: TAG_W];
    assign hit       = arr_rd_valid && (arr_rd_tag == pa_tag);
    assign hit_word  = arr_rd_line[WORD_BITS*wsel_q +: WORD_BITS];
    assign beat_word = (we_q && beat_q == wsel_q)
                     ? merge_bytes(mem_rdata, wdata_q, be_q) : mem_rdata;
    assign beat_done = mem_ack && beat_q == LAST_BEAT;

    // State register and request bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            wsel_q  <= '0;
            we_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
            pa_q    <= '0;
            beat_q  <= '0;
            fill_q  <= '0;
            given_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        idx_q   <= req_vaddr[OFF_W +: IDX_W];
                        wsel_q  <= req_vaddr[BOFF_W +: WSEL_W];
                        we_q    <= req_we;
                        be_q    <= req_be;
                        wdata_q <= req_wdata;
                    end
                end
                ST_LOOKUP: begin
                    pa_q    <= req_paddr[ADDR_W-1:BOFF_W];
                    beat_q  <= '0;
                    given_q <= 1'b0;
                end
                ST_EVICT: begin
                    if (mem_ack) beat_q <= beat_q + 1'b1;
                end
                ST_REFILL: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        fill_q <= put_word(fill_q, beat_q, beat_word);
                        if (beat_q == wsel_q) given_q <= 1'b1;
                    end
                end
                ST_BYPASS: ;
                default: ;
            endcase
        end
    end

    // Next state and all outputs
    always_comb begin
        state_d      = state_q;
        req_ready    = 1'b0;
        stall        = 1'b0;
        resp_valid   = 1'b0;
        resp_rdata   = '0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = '0;
        mem_be       = '0;
        mem_wdata    = '0;
        arr_rd_en    = 1'b0;
        arr_rd_idx   = req_vaddr[OFF_W +: IDX_W];
        arr_wr_en    = 1'b0;
        arr_wr_idx   = idx_q;
        arr_wr_line  = arr_rd_line;
        arr_wr_tag   = pa_q[PA_W-1 -: TAG_W];
        arr_wr_dirty = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    arr_rd_en = 1'b1;
                    state_d   = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (pa_uncached) begin
                    stall   = 1'b1;
                    state_d = ST_BYPASS;
                end else if (hit) begin
                    resp_valid = 1'b1;
                    resp_rdata = hit_word;
                    if (we_q) begin
                        arr_wr_en    = 1'b1;
                        arr_wr_line  = put_word(arr_rd_line, wsel_q,
                                                merge_bytes(hit_word, wdata_q, be_q));
                        arr_wr_tag   = arr_rd_tag;
                        arr_wr_dirty = 1'b1;
                    end
                    state_d = ST_IDLE;
                end else begin
                    stall   = 1'b1;
                    state_d = (arr_rd_valid && arr_rd_dirty) ? ST_EVICT : ST_REFILL;
                end
            end
            ST_EVICT: begin
                stall     = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = '1;
                mem_addr  = {arr_rd_tag, idx_q, beat_q, {BOFF_W{1'b0}}};
                mem_wdata = arr_rd_line[WORD_BITS*beat_q +: WORD_BITS];
                if (beat_done) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req  = 1'b1;
                mem_be   = '1;
                mem_addr = {pa_q[PA_W-1:WSEL_W], beat_q, {BOFF_W{1'b0}}};
                if (mem_ack && beat_q == wsel_q) begin
                    resp_valid = 1'b1;
                    resp_rdata = mem_rdata;
                end
                stall = !given_q && !resp_valid;
                if (beat_done) begin
                    arr_wr_en    = 1'b1;
                    arr_wr_line  = put_word(fill_q, beat_q, beat_word);
                    arr_wr_dirty = we_q;
                    state_d      = ST_IDLE;
                end
            end
            ST_BYPASS: begin
                mem_req   = 1'b1;
                mem_we    = we_q;
                mem_be    = be_q;
                mem_addr  = {pa_q, {BOFF_W{1'b0}}};
                mem_wdata = wdata_q;
                stall     = !mem_ack;
                if (mem_ack) begin
                    resp_valid = 1'b1;
                    resp_rdata = mem_rdata;
                    state_d    = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
    parameter int ADDR_W    = 32,
    parameter int LINES     = 512,
    parameter int LINE_BITS = 128,
    parameter int WORD_BITS = 32,
    localparam int BE_W     = WORD_BITS / 8,
    localparam int IDX_W    = $clog2(LINES),
    localparam int OFF_W    = $clog2(LINE_BITS / 8),
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_vaddr,
    input  logic [BE_W-1:0]      req_be,
    input  logic [WORD_BITS-1:0] req_wdata,
    input  logic [ADDR_W-1:0]    req_paddr,
    input  logic                 pa_uncached,
    output logic                 req_ready,
    output logic                 stall,
    output logic                 resp_valid,
    output logic [WORD_BITS-1:0] resp_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BE_W-1:0]      mem_be,
    output logic [WORD_BITS-1:0] mem_wdata,
    input  logic                 mem_ack,
    input  logic [WORD_BITS-1:0] mem_rdata
);

    logic                 arr_rd_en;
    logic [IDX_W-1:0]     arr_rd_idx;
    logic [LINE_BITS-1:0] arr_rd_line;
    logic [TAG_W-1:0]     arr_rd_tag;
    logic                 arr_rd_valid;
    logic                 arr_rd_dirty;
    logic                 arr_wr_en;
    logic [IDX_W-1:0]     arr_wr_idx;
    logic [LINE_BITS-1:0] arr_wr_line;
    logic [TAG_W-1:0]     arr_wr_tag;
    logic                 arr_wr_dirty;

    vipt_dcache_store #(
        .LINES     (LINES),
        .LINE_BITS (LINE_BITS),
        .TAG_W     (TAG_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (arr_rd_en),
        .rd_idx   (arr_rd_idx),
        .rd_line  (arr_rd_line),
        .rd_tag   (arr_rd_tag),
        .rd_valid (arr_rd_valid),
        .rd_dirty (arr_rd_dirty),
        .wr_en    (arr_wr_en),
        .wr_idx   (arr_wr_idx),
        .wr_line  (arr_wr_line),
        .wr_tag   (arr_wr_tag),
        .wr_dirty (arr_wr_dirty)
    );

    vipt_dcache_ctrl #(
        .ADDR_W    (ADDR_W),
        .LINES     (LINES),
        .LINE_BITS (LINE_BITS),
        .WORD_BITS (WORD_BITS)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_we       (req_we),
        .req_vaddr    (req_vaddr),
        .req_be       (req_be),
        .req_wdata    (req_wdata),
        .req_paddr    (req_paddr),
        .pa_uncached  (pa_uncached),
        .req_ready    (req_ready),
        .stall        (stall),
        .resp_valid   (resp_valid),
        .resp_rdata   (resp_rdata),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_be       (mem_be),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .arr_rd_en    (arr_rd_en),
        .arr_rd_idx   (arr_rd_idx),
        .arr_rd_line  (arr_rd_line),
        .arr_rd_tag   (arr_rd_tag),
        .arr_rd_valid (arr_rd_valid),
        .arr_rd_dirty (arr_rd_dirty),
        .arr_wr_en    (arr_wr_en),
        .arr_wr_idx   (arr_wr_idx),
        .arr_wr_line  (arr_wr_line),
        .arr_wr_tag   (arr_wr_tag),
        .arr_wr_dirty (arr_wr_dirty)
    );

endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              stall,
    input logic              resp_valid,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);

    // R5: an idle cache never signals an outstanding word
    p_ready_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !stall);

    // R5: stall and completion are exclusive
    p_stall_no_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !resp_valid);

    // R4: a memory beat holds its request and address until acknowledged
    p_hold_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R2: an accepted request is followed by the lookup cycle, with no memory traffic
    p_accept_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && !mem_req);

    // R11: while idle, nothing is in flight
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req && !resp_valid);

    // R2: each access completes in exactly one cycle
    p_single_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

endmodule

bind vipt_dcache vipt_dcache_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .stall      (stall),
    .resp_valid (resp_valid),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr)
);

// File: tb/vipt_dcache_tb_top.sv
module vipt_dcache_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_paddr = '0;
    logic        pa_uncached = 1'b0;
    logic        req_ready, stall, resp_valid;
    logic [31:0] resp_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    vipt_dcache dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_vaddr(req_vaddr), .req_be(req_be), .req_wdata(req_wdata),
        .req_paddr(req_paddr), .pa_uncached(pa_uncached), .req_ready(req_ready),
        .stall(stall), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // ---------------- memory model ----------------
    logic [31:0] wt_addr [32];
    logic [31:0] wt_data [32];
    int          wt_n = 0;
    logic [31:0] lg_addr [16];
    logic [31:0] lg_data [16];
    logic [3:0]  lg_be   [16];
    logic        lg_we   [16];
    int          lg_n = 0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'hC3A5_5A3C;
    endfunction

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        logic [31:0] v;
        v = pat(a);
        for (int i = 0; i < wt_n; i++) if (wt_addr[i] == a) v = wt_data[i];
        return v;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    // Acknowledge every other cycle; the beat completes at the following edge
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                mem_ack = 1'b1;
                mem_rdata = mem_read({mem_addr[31:2], 2'b00});
                if (lg_n < 16) begin
                    lg_addr[lg_n] = mem_addr; lg_data[lg_n] = mem_wdata;
                    lg_be[lg_n] = mem_be; lg_we[lg_n] = mem_we;
                    lg_n++;
                end
                if (mem_we && wt_n < 32) begin
                    wt_addr[wt_n] = {mem_addr[31:2], 2'b00};
                    wt_data[wt_n] = merge(mem_read({mem_addr[31:2], 2'b00}), mem_wdata, mem_be);
                    wt_n++;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [31:0] rd;
    int          rcyc, dcyc;
    logic        stall1;

    // One access; cycle 1 is LOOKUP. poke raises a store request while busy.
    task automatic access(input logic [31:0] va, input logic [31:0] pa, input bit unc,
                          input bit we, input logic [3:0] be, input logic [31:0] wd,
                          input bit poke);
        int cyc;
        lg_n = 0; rcyc = -1; dcyc = -1; rd = '0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_we = we; req_be = be; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_paddr = pa; pa_uncached = unc;
        cyc = 1;
        forever begin
            #5;
            if (cyc == 1) stall1 = stall;
            if (resp_valid && rcyc < 0) begin rcyc = cyc; rd = resp_rdata; end
            if (req_ready && cyc > 1) begin dcyc = cyc; break; end
            if (cyc > 80) break;
            @(negedge clk);
            cyc++;
            if (poke && rcyc < 0 && cyc >= 2) begin
                req_valid = 1'b1; req_we = 1'b1; req_be = 4'hF; req_wdata = 32'hFFFF_FFFF;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        #5;
        chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 1);
        chk(stall === 1'b0 && resp_valid === 1'b0, "R1 stall/resp", 32'(stall), 0);
        chk(mem_req === 1'b0, "R1 mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_cold_miss();
        // load word 2, with ignored store requests raised during the miss (R11)
        access(32'h0000_1048, 32'h0012_3048, 0, 0, 4'hF, 0, 1);
        chk(stall1 === 1'b1, "R1 first access misses", 32'(stall1), 1);
        chk(rcyc == 6, "R5 resp cycle", rcyc, 6);
        chk(rd == pat(32'h0012_3048), "R5 resp data", rd, pat(32'h0012_3048));
        chk(dcyc == 9, "R5 ready return", dcyc, 9);
        chk(lg_n == 4, "R4 R9 R11 beat count", lg_n, 4);
        for (int i = 0; i < 4 && i < lg_n; i++)
            chk(!lg_we[i] && lg_addr[i] == 32'h0012_3040 + 32'(4*i), "R4 refill order",
                lg_addr[i], 32'h0012_3040 + 32'(4*i));
    endtask

    task automatic t_hit();
        access(32'h0000_1048, 32'h0012_3048, 0, 0, 4'hF, 0, 0);
        chk(rcyc == 1 && lg_n == 0, "R2 hit timing", rcyc, 1);
        chk(rd == pat(32'h0012_3048), "R11 poke ignored", rd, pat(32'h0012_3048));
    endtask

    task automatic t_phys_tag();
        access(32'h7771_104C, 32'h0012_304C, 0, 0, 4'hF, 0, 0);
        chk(rcyc == 1 && lg_n == 0, "R3 other virtual tag hits", rcyc, 1);
        chk(rd == pat(32'h0012_304C), "R3 hit data", rd, pat(32'h0012_304C));
        access(32'h0000_1044, 32'h0045_7044, 0, 0, 4'hF, 0, 0);
        chk(rcyc == 4 && lg_n == 4, "R3 other physical tag misses", rcyc, 4);
        chk(rd == pat(32'h0045_7044), "R3 refill data", rd, pat(32'h0045_7044));
    endtask

    task automatic t_store_hit();
        logic [31:0] e;
        e = merge(pat(32'h0045_7044), 32'hAABB_CCDD, 4'b0101);
        access(32'h0000_1044, 32'h0045_7044, 0, 1, 4'b0101, 32'hAABB_CCDD, 0);
        chk(rcyc == 1 && lg_n == 0, "R6 store hit no traffic", rcyc, 1);
        access(32'h0000_1044, 32'h0045_7044, 0, 0, 4'hF, 0, 0);
        chk(rd == e, "R6 merged readback", rd, e);
    endtask

    task automatic t_dirty_evict();
        logic [31:0] e;
        access(32'h0000_1040, 32'h0012_3040, 0, 0, 4'hF, 0, 0);
        chk(lg_n == 8, "R8 beat count", lg_n, 8);
        for (int i = 0; i < 4 && i < lg_n; i++) begin
            e = (i == 1) ? merge(pat(32'h0045_7044), 32'hAABB_CCDD, 4'b0101)
                         : pat(32'h0045_7040 + 32'(4*i));
            chk(lg_we[i] && lg_be[i] == 4'hF && lg_addr[i] == 32'h0045_7040 + 32'(4*i),
                "R8 writeback addr", lg_addr[i], 32'h0045_7040 + 32'(4*i));
            chk(lg_data[i] == e, "R8 writeback data", lg_data[i], e);
        end
        chk(rcyc == 10, "R8 resp after writeback", rcyc, 10);
        chk(rd == pat(32'h0012_3040), "R8 refill data", rd, pat(32'h0012_3040));
    endtask

    task automatic t_store_miss();
        logic [31:0] e;
        e = merge(pat(32'h0089_A010), 32'h1122_3344, 4'b1000);
        access(32'h0000_2010, 32'h0089_A010, 0, 1, 4'b1000, 32'h1122_3344, 0);
        chk(rcyc == 2 && lg_n == 4 && !lg_we[0], "R7 allocate refill", rcyc, 2);
        access(32'h0000_2010, 32'h0089_A010, 0, 0, 4'hF, 0, 0);
        chk(rcyc == 1 && rd == e, "R7 merged after allocate", rd, e);
        access(32'h0000_2010, 32'h00AB_A010, 0, 0, 4'hF, 0, 0);
        chk(lg_n == 8 && lg_we[0] && lg_addr[0] == 32'h0089_A010, "R7 line left dirty",
            lg_addr[0], 32'h0089_A010);
        chk(lg_data[0] == e, "R7 written back merged", lg_data[0], e);
    endtask

    task automatic t_uncached();
        access(32'h0000_1040, 32'h0012_3040, 1, 0, 4'hF, 0, 0);
        chk(rcyc == 2 && lg_n == 1 && !lg_we[0] && lg_addr[0] == 32'h0012_3040,
            "R10 uncached load", lg_addr[0], 32'h0012_3040);
        chk(rd == pat(32'h0012_3040), "R10 uncached data", rd, pat(32'h0012_3040));
        access(32'h0000_1044, 32'h0012_3044, 1, 1, 4'b0011, 32'hDEAD_BEEF, 0);
        chk(lg_n == 1 && lg_we[0] && lg_be[0] == 4'b0011 && lg_data[0] == 32'hDEAD_BEEF,
            "R10 uncached store", lg_data[0], 32'hDEAD_BEEF);
        access(32'h0000_1044, 32'h0012_3044, 0, 0, 4'hF, 0, 0);
        chk(rcyc == 1 && lg_n == 0 && rd == pat(32'h0012_3044), "R10 array untouched",
            rd, pat(32'h0012_3044));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold_miss();
        t_hit();
        t_phys_tag();
        t_store_hit();
        t_dirty_evict();
        t_store_miss();
        t_uncached();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule